// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects eight interrupt request lines and presents a single interrupt line to a processor. Each line can be captured on a rising edge or followed as a level. Each line can be masked on its own. Requests that win arbitration are tracked in an in-service set. While a request is in service, only a strictly higher-priority request can raise the interrupt line again, so service routines can nest. Priority is fixed: line 0 is the highest and line 7 the lowest.

The processor acknowledges with two one-cycle pulses on `inta_i`. The first pulse selects the winning line, moves it from the request set to the in-service set and, when the block is set up as a cascade master, drives the winning line number on `cas_o`. The second pulse returns a vector byte formed from a programmed base and the line number. Lines leave the in-service set through an end-of-interrupt command written by software, or automatically at the second pulse. A small register interface with a one-bit address handles setup, masking, commands and status reads. All inputs are synchronous to `clk_i`.

Top module: `prio_intc`

## Requirements
- R1: After reset, `int_o` is 0, `vec_valid_o` is 0, the mask reads 0xFF (all masked), and the request and in-service sets read 0x00.
- R2: A write to address 0 with bit 4 set is setup word one. Its bit 3 selects level mode (1) or edge mode (0). It clears the mask, the request set and the in-service set, selects request status and turns automatic end-of-interrupt and master mode off. The next write to address 1 is setup word two: base in bits 7:3, automatic end-of-interrupt in bit 0, master mode in bit 1.
- R3: In edge mode, a request bit is set by a low-to-high step on an unmasked line. It drops if the line goes low before acknowledge. A line held high after acknowledge does not request again.
- R4: In level mode, each request bit follows the high level of its unmasked line, one cycle later.
- R5: Outside the setup sequence, a write to address 1 loads the mask (1 = masked). A masked line never sets its request bit or raises `int_o`. Masking line 0 does not block line 1.
- R6: `int_o` is high exactly when an unmasked pending request has a lower line number than every in-service bit.
- R7: On the first acknowledge pulse, the lowest-numbered request that drives `int_o` is selected: its request bit is cleared and its in-service bit is set.
- R8: On the second acknowledge pulse, `vec_valid_o` is 1 for that cycle and `vec_o` equals the base in bits 7:3 and the selected line number in bits 2:0. Otherwise `vec_o` is 0.
- R9: If no request drives `int_o` at the first pulse, line number 7 is reported and no in-service bit changes.
- R10: Writing 0x20 to address 0 clears the lowest-numbered in-service bit. Writing 0x60 plus n clears in-service bit n.
- R11: With automatic end-of-interrupt on, the selected in-service bit is cleared at the second acknowledge pulse.
- R12: While `sel_i` and `rd_i` are high, address 1 reads the mask. Address 0 reads the request set after a write of 0x0A (and after setup), or the in-service set after a write of 0x0B. `rdata_o` is 0 when no read is in progress.
- R13: In master mode, `cas_o` carries the selected line number from the cycle after the first pulse through the second pulse. At all other times it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access select |
| addr_i | input | 1 | Register address |
| wr_i | input | 1 | Write strobe, one cycle |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| irq_i | input | 8 | Request lines, line 0 highest priority |
| int_o | output | 1 | Interrupt to the processor |
| inta_i | input | 1 | Acknowledge pulse, two per sequence |
| vec_valid_o | output | 1 | Vector present on this cycle |
| vec_o | output | 8 | Vector byte |
| cas_o | output | 3 | Slave ID in master mode |

## Verification
A corrupted request or in-service bit changes `int_o` in the cycle that follows. When the request set is read back, the wrong bit also shows on `rdata_o`. A wrong selection at the first pulse shows one cycle later on `cas_o` in master mode, and on `vec_o` at the second pulse. A lost or stale in-service bit shows as a missing or extra interrupt right after the next end-of-interrupt command. The bench mirrors every register in a behavioural model and compares all outputs on every cycle, so any such fault is reported within one clock of reaching a port.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic {RSEL_REQ = 1'b0, RSEL_ISR = 1'b1} rsel_e;

  localparam int CMD_INIT_BIT   = 4;
  localparam int CMD_RSEL_BIT   = 3;
  localparam int CMD_EOI_BIT    = 5;
  localparam int CMD_SPEC_BIT   = 6;
  localparam int CFG_LEVEL_BIT  = 3;
  localparam int CFG_AEOI_BIT   = 0;
  localparam int CFG_MASTER_BIT = 1;

  typedef struct packed {
    logic level;
    logic aeoi;
    logic master;
  } cfg_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int N_IRQ  = 8,
  parameter int DATA_W = 8,
  localparam int ID_W   = $clog2(N_IRQ),
  localparam int BASE_W = DATA_W - ID_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_IRQ-1:0]  irr_i,
  input  logic [N_IRQ-1:0]  isr_i,
  output logic [DATA_W-1:0] rdata_o,
  output cfg_t              cfg_o,
  output logic [BASE_W-1:0] base_o,
  output logic [N_IRQ-1:0]  mask_o,
  output logic              init_o,
  output logic              eoi_ns_o,
  output logic              eoi_sp_o,
  output logic [ID_W-1:0]   eoi_lvl_o
);
  logic  wr_en, cmd0, cmd1, plain0;
  logic  init_wait_q;
  rsel_e rsel_q;

  assign wr_en  = sel_i & wr_i;
  assign cmd0   = wr_en & ~addr_i;
  assign cmd1   = wr_en & addr_i;
  assign plain0 = cmd0 & ~wdata_i[CMD_INIT_BIT] & ~wdata_i[CMD_RSEL_BIT];

  assign init_o    = cmd0 & wdata_i[CMD_INIT_BIT];
  assign eoi_ns_o  = plain0 & wdata_i[CMD_EOI_BIT] & ~wdata_i[CMD_SPEC_BIT];
  assign eoi_sp_o  = plain0 & wdata_i[CMD_EOI_BIT] & wdata_i[CMD_SPEC_BIT];
  assign eoi_lvl_o = wdata_i[ID_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o       <= '0;
      base_o      <= '0;
      mask_o      <= '1;
      rsel_q      <= RSEL_REQ;
      init_wait_q <= 1'b0;
    end else if (init_o) begin
      cfg_o.level  <= wdata_i[CFG_LEVEL_BIT];
      cfg_o.aeoi   <= 1'b0;
      cfg_o.master <= 1'b0;
      mask_o       <= '0;
      rsel_q       <= RSEL_REQ;
      init_wait_q  <= 1'b1;
    end else if (cmd0 && wdata_i[CMD_RSEL_BIT]) begin
      if (wdata_i[1:0] == 2'b10) rsel_q <= RSEL_REQ;
      else if (wdata_i[1:0] == 2'b11) rsel_q <= RSEL_ISR;
    end else if (cmd1) begin
      if (init_wait_q) begin
        base_o       <= wdata_i[DATA_W-1:ID_W];
        cfg_o.aeoi   <= wdata_i[CFG_AEOI_BIT];
        cfg_o.master <= wdata_i[CFG_MASTER_BIT];
        init_wait_q  <= 1'b0;
      end else begin
        mask_o <= wdata_i[N_IRQ-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i && rd_i) begin
      if (addr_i)                 rdata_o = DATA_W'(mask_o);
      else if (rsel_q == RSEL_ISR) rdata_o = DATA_W'(isr_i);
      else                        rdata_o = DATA_W'(irr_i);
    end
  end
endmodule

// File: rtl/intc_req.sv
module intc_req #(
  parameter int N_IRQ = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [N_IRQ-1:0] mask_i,
  input  logic             level_i,
  input  logic             init_i,
  input  logic [N_IRQ-1:0] ack_clr_i,
  output logic [N_IRQ-1:0] irr_o
);
  logic [N_IRQ-1:0] prev_q, rise, irr_d;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_bit
    assign rise[g]  = irq_i[g] & ~prev_q[g];
    assign irr_d[g] = (init_i || ack_clr_i[g]) ? 1'b0 :
                      level_i ? (irq_i[g] & ~mask_i[g]) :
                      ((rise[g] & ~mask_i[g]) | (irr_o[g] & irq_i[g]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      irr_o  <= '0;
    end else begin
      prev_q <= irq_i;
      irr_o  <= irr_d;
    end
  end
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter int N_IRQ = 8,
  localparam int ID_W = $clog2(N_IRQ)
) (
  input  logic [N_IRQ-1:0] pend_i,
  input  logic [N_IRQ-1:0] isr_i,
  output logic             hit_o,
  output logic [ID_W-1:0]  sel_idx_o,
  output logic             top_valid_o,
  output logic [ID_W-1:0]  top_idx_o
);
  logic [N_IRQ-1:0] blk, cand;

  // a request is blocked by any in-service bit at its own or higher priority
  for (genvar g = 0; g < N_IRQ; g++) begin : g_blk
    assign blk[g] = |isr_i[g:0];
  end
  assign cand = pend_i & ~blk;

  always_comb begin
    hit_o       = |cand;
    top_valid_o = |isr_i;
    sel_idx_o   = '0;
    top_idx_o   = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (cand[i])  sel_idx_o = ID_W'(i);
      if (isr_i[i]) top_idx_o = ID_W'(i);
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int N_IRQ  = 8,
  parameter int DATA_W = 8,
  localparam int ID_W   = $clog2(N_IRQ),
  localparam int BASE_W = DATA_W - ID_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_IRQ-1:0]  irq_i,
  output logic              int_o,
  input  logic              inta_i,
  output logic              vec_valid_o,
  output logic [DATA_W-1:0] vec_o,
  output logic [ID_W-1:0]   cas_o
);
  cfg_t              cfg;
  logic [BASE_W-1:0] base;
  logic [N_IRQ-1:0]  mask_w, irr_w, isr_q, isr_d, ack_clr;
  logic              init, eoi_ns, eoi_sp, hit, top_valid;
  logic [ID_W-1:0]   eoi_lvl, sel_idx, top_idx, lvl_q;
  logic              ack_q, spur_q, ack1, ack2;

  intc_ctrl #(.N_IRQ(N_IRQ), .DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni, .sel_i, .addr_i, .wr_i, .rd_i, .wdata_i,
    .irr_i(irr_w), .isr_i(isr_q), .rdata_o,
    .cfg_o(cfg), .base_o(base), .mask_o(mask_w),
    .init_o(init), .eoi_ns_o(eoi_ns), .eoi_sp_o(eoi_sp), .eoi_lvl_o(eoi_lvl)
  );

  intc_req #(.N_IRQ(N_IRQ)) u_req (
    .clk_i, .rst_ni, .irq_i, .mask_i(mask_w), .level_i(cfg.level),
    .init_i(init), .ack_clr_i(ack_clr), .irr_o(irr_w)
  );

  intc_prio #(.N_IRQ(N_IRQ)) u_prio (
    .pend_i(irr_w & ~mask_w), .isr_i(isr_q), .hit_o(hit),
    .sel_idx_o(sel_idx), .top_valid_o(top_valid), .top_idx_o(top_idx)
  );

  assign ack1    = inta_i & ~ack_q;
  assign ack2    = inta_i & ack_q;
  assign ack_clr = (ack1 && hit) ? (N_IRQ'(1) << sel_idx) : '0;

  always_comb begin
    isr_d = isr_q;
    if (ack1 && hit)                    isr_d[sel_idx] = 1'b1;
    if (ack2 && cfg.aeoi && !spur_q)    isr_d[lvl_q]   = 1'b0;
    if (eoi_ns && top_valid)            isr_d[top_idx] = 1'b0;
    if (eoi_sp)                         isr_d[eoi_lvl] = 1'b0;
    if (init)                           isr_d          = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q  <= '0;
      ack_q  <= 1'b0;
      lvl_q  <= '0;
      spur_q <= 1'b0;
    end else begin
      isr_q <= isr_d;
      if (init) ack_q <= 1'b0;
      else if (ack1) begin
        ack_q  <= 1'b1;
        lvl_q  <= hit ? sel_idx : '1;
        spur_q <= ~hit;
      end else if (ack2) ack_q <= 1'b0;
    end
  end

  assign int_o       = hit;
  assign vec_valid_o = ack2;
  assign vec_o       = ack2 ? {base, lvl_q} : '0;
  assign cas_o       = (cfg.master && ack_q) ? lvl_q : '0;
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int N_IRQ = 8,
  localparam int ID_W = $clog2(N_IRQ)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             int_o,
  input logic             vec_valid_o,
  input logic [ID_W-1:0]  cas_o,
  input logic [N_IRQ-1:0] irr_q,
  input logic [N_IRQ-1:0] mask_q,
  input logic [N_IRQ-1:0] isr_q,
  input logic             ack_q
);
  p_int_needs_pending_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> (|(irr_q & ~mask_q)));

  p_vec_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |=> !vec_valid_o);

  p_cas_stable_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_q && $past(ack_q)) |-> $stable(cas_o));

  p_isr_one_bit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> ($countones(isr_q ^ $past(isr_q)) <= 1));

  p_masked_no_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irr_q & ~$past(irr_q) & $past(mask_q)) == '0);
endmodule

bind prio_intc intc_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk_i, .rst_ni, .int_o, .vec_valid_o, .cas_o,
  .irr_q(irr_w), .mask_q(mask_w), .isr_q(isr_q), .ack_q(ack_q)
);

// File: tb/prio_intc_bench.sv
module prio_intc_bench;
  localparam int PER = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       sel = 0, addr = 0, wr = 0, rd = 0, inta = 0;
  logic [7:0] wd = 0, irq = 0;
  logic [7:0] rdata, vec;
  logic       intr, vvld;
  logic [2:0] cas;
  int total = 0, bad = 0;

  always #(PER/2) clk = ~clk;

  prio_intc u_prio_intc (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wd), .rdata_o(rdata), .irq_i(irq), .int_o(intr), .inta_i(inta),
    .vec_valid_o(vvld), .vec_o(vec), .cas_o(cas)
  );

  // behavioural reference state
  logic [7:0] m_irr, m_isr, m_mask, m_prev;
  logic [4:0] m_base;
  logic       m_level, m_aeoi, m_master, m_rsel, m_initw, m_ph, m_spur;
  int         m_lvl;

  function automatic int lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic int winner(input logic [7:0] r, m, s);
    int top = lowest(s);
    for (int i = 0; i < top; i++) if (r[i] && !m[i]) return i;
    return -1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin : upd
    logic [7:0] nirr, nisr;
    int w;
    if (!rst_n) begin
      m_irr = 0; m_isr = 0; m_mask = 8'hFF; m_prev = 0; m_base = 0;
      m_level = 0; m_aeoi = 0; m_master = 0; m_rsel = 0; m_initw = 0;
      m_ph = 0; m_spur = 0; m_lvl = 0;
    end else begin
      w = winner(m_irr, m_mask, m_isr);
      nisr = m_isr;
      for (int i = 0; i < 8; i++) begin
        if (m_level) nirr[i] = irq[i] & ~m_mask[i];
        else nirr[i] = (irq[i] & ~m_prev[i] & ~m_mask[i]) | (m_irr[i] & irq[i]);
      end
      if (inta && !m_ph) begin
        if (w >= 0) begin nirr[w] = 0; nisr[w] = 1; end
        m_lvl = (w >= 0) ? w : 7;
        m_spur = (w < 0);
        m_ph = 1;
      end else if (inta && m_ph) begin
        if (m_aeoi && !m_spur) nisr[m_lvl] = 0;
        m_ph = 0;
      end
      if (sel && wr) begin
        if (!addr) begin
          if (wd[4]) begin
            m_level = wd[3]; m_mask = 0; m_rsel = 0; m_aeoi = 0; m_master = 0;
            m_initw = 1; nirr = 0; nisr = 0; m_ph = 0;
          end else if (wd[3]) begin
            if (wd[1:0] == 2) m_rsel = 0;
            else if (wd[1:0] == 3) m_rsel = 1;
          end else if (wd[5]) begin
            if (wd[6]) nisr[wd[2:0]] = 0;
            else if (m_isr != 0) nisr[lowest(m_isr)] = 0;
          end
        end else if (m_initw) begin
          m_base = wd[7:3]; m_aeoi = wd[0]; m_master = wd[1]; m_initw = 0;
        end else m_mask = wd;
      end
      m_irr = nirr; m_isr = nisr; m_prev = irq;
    end
  end

  // cycle compare, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 int_o", intr, winner(m_irr, m_mask, m_isr) >= 0);
      chk("R8 vec_valid_o", vvld, inta && m_ph);
      chk("R8 vec_o", vec, (inta && m_ph) ? {m_base, 3'(m_lvl)} : 8'h00);
      chk("R13 cas_o", cas, (m_master && m_ph) ? m_lvl : 0);
      chk("R12 rdata_o", rdata, !(sel && rd) ? 0 : addr ? m_mask : m_rsel ? m_isr : m_irr);
    end
  end

  task automatic wreg(input logic a, input logic [7:0] d);
    @(posedge clk); #2 sel = 1; wr = 1; addr = a; wd = d;
    @(posedge clk); #2 sel = 0; wr = 0;
  endtask

  task automatic rreg(input logic a, input int exp, input string tag);
    @(posedge clk); #2 sel = 1; rd = 1; addr = a;
    @(negedge clk); chk(tag, rdata, exp);
    @(posedge clk); #2 sel = 0; rd = 0;
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(posedge clk); #2 irq = v;
  endtask

  task automatic int_is(input int exp, input string tag);
    @(posedge clk); @(negedge clk); chk(tag, intr, exp);
  endtask

  task automatic do_ack(input int exp_cas, input int exp_vec, input string tc, input string tv);
    @(posedge clk); #2 inta = 1;
    @(posedge clk); #2 inta = 0;
    @(negedge clk); chk(tc, cas, exp_cas);
    @(posedge clk); #2 inta = 1;
    @(negedge clk); chk(tv, vvld, 1); chk(tv, vec, exp_vec);
    @(posedge clk); #2 inta = 0;
  endtask

  initial begin
    #(PER * 150000);
    total++; bad++;
    $display("FAIL watchdog act=%0h exp=%0h", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk("R1 int_o after reset", intr, 0);
    chk("R1 vec_valid_o after reset", vvld, 0);
    chk("R12 idle rdata_o", rdata, 0);
    rreg(1, 8'hFF, "R1 mask after reset");
    rreg(0, 8'h00, "R1 request after reset");

    wreg(0, 8'h10);                         // edge mode
    wreg(1, 8'h42);                         // base 0x40, master
    rreg(1, 8'h00, "R2 mask cleared by setup");

    set_irq(8'h08);
    int_is(1, "R6 single request");
    rreg(0, 8'h08, "R3 edge captured");
    do_ack(3, 8'h43, "R13 cas shows line", "R8 vector line 3");
    wreg(0, 8'h0B);
    rreg(0, 8'h08, "R7 in-service set");
    wreg(0, 8'h0A);
    rreg(0, 8'h00, "R3 held line no re-request");

    set_irq(8'h28);
    int_is(0, "R6 lower blocked");
    set_irq(8'h2A);
    int_is(1, "R6 higher nests");
    do_ack(1, 8'h41, "R13 cas line 1", "R7 vector line 1");
    wreg(0, 8'h0B);
    rreg(0, 8'h0A, "R7 nested in-service");
    wreg(0, 8'h20);
    rreg(0, 8'h08, "R10 non-specific eoi");
    int_is(0, "R6 line 5 still blocked");
    wreg(0, 8'h63);
    rreg(0, 8'h00, "R10 specific eoi");
    int_is(1, "R6 line 5 after eoi");

    wreg(1, 8'h21);
    int_is(0, "R5 masked line quiet");
    set_irq(8'h00);
    set_irq(8'h03);
    wreg(0, 8'h0A);
    rreg(0, 8'h02, "R5 mask line0 keeps line1");
    int_is(1, "R5 line1 raises int");

    set_irq(8'h00);
    int_is(0, "R3 drop before ack");
    do_ack(7, 8'h47, "R13 cas spurious", "R9 spurious vector");
    wreg(0, 8'h0B);
    rreg(0, 8'h00, "R9 no in-service change");

    wreg(0, 8'h18);                         // level mode
    wreg(1, 8'h81);                         // base 0x80, auto eoi
    set_irq(8'h04);
    rreg(0, 8'h04, "R4 level follows");
    do_ack(0, 8'h82, "R13 cas zero non-master", "R8 vector line 2");
    wreg(0, 8'h0B);
    rreg(0, 8'h00, "R11 auto eoi cleared");
    wreg(0, 8'h0A);
    rreg(0, 8'h04, "R4 level reasserts");
    set_irq(8'h00);
    rreg(0, 8'h00, "R4 level drops");
    wreg(1, 8'h10);
    rreg(1, 8'h10, "R5 mask write after setup");

    repeat (2) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule